// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block turns one 32-bit fixed-length instruction word of a small three-format load/store machine into the control and operand-select signals that the execute stage needs. It splits the word into its register-number, shift-amount, immediate and jump-target fields. It then decodes the opcode, and for the register format also the function code, into an ALU operation select, a register-write enable, memory read and write strobes, branch and jump flags and a link-write flag.

Two choices are made inside the block. The destination register depends on the format: the third register field for register-format operations, the second register field for immediate-format operations, and register 31 for jump-and-link. The 16-bit immediate is sign-extended, zero-extended or moved to the upper half, depending on the class of the opcode.

The block is combinational. The parameter `REGISTERED` adds one output register with a synchronous active-high reset, for use when the decode has to be retimed into the next stage.

Top module: `idec_top`

## Requirements
- R1: `rs_o` = instr[25:21], `rt_o` = instr[20:16], `shamt_o` = instr[10:6] and `jtgt_o` = instr[25:0] for every instruction word.
- R2: Opcode 0 decodes the function code instr[5:0] into `alu_op_o` as follows: 0x20 and 0x21 give 0 (add); 0x22 and 0x23 give 1 (sub); 0x24 gives 2 (and); 0x25 gives 3 (or); 0x26 gives 4 (xor); 0x27 gives 5 (nor); 0x2A gives 6 (signed less-than); 0x2B gives 7 (unsigned less-than); 0x00 gives 8 (sll); 0x02 gives 9 (srl); 0x03 gives 10 (sra).
- R3: `dst_o` is instr[15:11] for register-format ALU operations, instr[20:16] for immediate ALU operations, `lui` and loads, and 31 for jump-and-link. It is 0 for every instruction that writes no register.
- R4: `reg_we_o` is 1 only for an instruction that writes a register and whose destination is not register 0.
- R5: `imm_o` is the zero extension of instr[15:0] for andi (12), ori (13) and xori (14). For every other opcode, including opcode 0 and illegal words, it is the sign extension of instr[15:0]. Opcodes 8 (addi), 9 (addiu), 10 (slti) and 11 (sltiu) select alu codes 0, 0, 6 and 7. Opcodes 12, 13 and 14 select alu codes 2, 3 and 4.
- R6: Opcode 15 (lui) gives `imm_o` = {instr[15:0], 16'h0} and alu code 11.
- R7: Opcode 35 (lw) raises `mem_rd_o`, and opcode 43 (sw) raises `mem_wr_o` and writes no register. Both use alu code 0 with a sign-extended offset. The two strobes are never high together.
- R8: Opcode 4 raises `br_eq_o` and opcode 5 raises `br_ne_o`. Both use alu code 1 and write no register.
- R9: Opcode 2 raises `jump_o` only. Opcode 3 raises `jump_o` and `link_o` and writes register 31. Opcode 0 with function code 0x08 raises `jump_reg_o` and writes no register. All three use alu code 0.
- R10: `ovf_chk_o` is 1 exactly for the function codes 0x20 and 0x22 and for opcode 8.
- R11: Any opcode not listed above, or opcode 0 with an unlisted function code, sets `illegal_o`. It then clears `reg_we_o`, both memory strobes, all branch, jump and link flags and `ovf_chk_o`, and sets `dst_o` = 0 and `alu_op_o` = 0.
- R12: With `REGISTERED` = 1, every output shows the decode of the word present at the previous rising clock edge. A cycle with `rst` high sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register number |
| rt_o | output | 5 | Second register field |
| dst_o | output | 5 | Selected destination register |
| shamt_o | output | 5 | Shift amount field |
| imm_o | output | 32 | Extended immediate |
| jtgt_o | output | 26 | Jump target field |
| alu_op_o | output | 4 | ALU operation code |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| br_eq_o | output | 1 | Branch if equal |
| br_ne_o | output | 1 | Branch if not equal |
| jump_o | output | 1 | Jump to the target field |
| jump_reg_o | output | 1 | Jump to a register value |
| link_o | output | 1 | Write the return address (PC+4) |
| ovf_chk_o | output | 1 | Signed overflow must be checked |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The bench builds two copies side by side, one with `REGISTERED` = 0 and one with `REGISTERED` = 1. Both see the same words, so the combinational decode and its one-cycle-late registered copy are compared against the same expected value, and the reset state of the register can be observed. The sweep covers all 64 opcodes and, under opcode 0, all 64 function codes. Each is combined with four field patterns: register fields of zero and nonzero, and immediates with the top bit clear and set. Every illegal code, every zero-destination suppression and both extension modes are therefore reached.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int unsigned IW     = 32;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned FN_W   = 6;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned TGT_W  = IW - OPC_W;
    localparam int unsigned EXT_W  = IW - IMM_W;
    localparam logic [REG_W-1:0] LINK_REG = '1;

    // opcodes
    localparam logic [OPC_W-1:0] OP_RFMT  = 6'd0;
    localparam logic [OPC_W-1:0] OP_J     = 6'd2;
    localparam logic [OPC_W-1:0] OP_JAL   = 6'd3;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OP_ADDIU = 6'd9;
    localparam logic [OPC_W-1:0] OP_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OP_SLTIU = 6'd11;
    localparam logic [OPC_W-1:0] OP_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OP_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OP_XORI  = 6'd14;
    localparam logic [OPC_W-1:0] OP_LUI   = 6'd15;
    localparam logic [OPC_W-1:0] OP_LW    = 6'd35;
    localparam logic [OPC_W-1:0] OP_SW    = 6'd43;

    // function codes under the register format
    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_NOR  = 4'd5,
        ALU_SLT  = 4'd6,
        ALU_SLTU = 4'd7,
        ALU_SLL  = 4'd8,
        ALU_SRL  = 4'd9,
        ALU_SRA  = 4'd10,
        ALU_LUI  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_sel_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] shamt;
        logic [FN_W-1:0]  funct;
        logic [IMM_W-1:0] imm;
        logic [TGT_W-1:0] tgt;
    } fields_t;

    typedef struct packed {
        alu_op_e  alu;
        dst_sel_e dst;
        ext_e     ext;
        logic     mem_rd;
        logic     mem_wr;
        logic     br_eq;
        logic     br_ne;
        logic     jmp;
        logic     jmp_reg;
        logic     link;
        logic     ovf_chk;
        logic     illegal;
    } ctrl_t;

    typedef struct packed {
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] shamt;
        logic [IW-1:0]    imm;
        logic [TGT_W-1:0] tgt;
        alu_op_e          alu;
        logic             we;
        logic             mem_rd;
        logic             mem_wr;
        logic             br_eq;
        logic             br_ne;
        logic             jmp;
        logic             jmp_reg;
        logic             link;
        logic             ovf_chk;
        logic             illegal;
    } dec_out_t;

    // quiet control word: no write, no strobe, no flag
    function automatic ctrl_t ctrl_quiet();
        ctrl_t c;
        c         = '0;
        c.alu     = ALU_ADD;
        c.dst     = DST_NONE;
        c.ext     = EXT_SIGN;
        return c;
    endfunction

    function automatic ctrl_t ctrl_alu(alu_op_e op, dst_sel_e d, ext_e e);
        ctrl_t c;
        c     = ctrl_quiet();
        c.alu = op;
        c.dst = d;
        c.ext = e;
        return c;
    endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [IW-1:0] instr_i,
    output fields_t       fields_o
);
    localparam int unsigned OPC_LSB = IW - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RT_LSB  = RS_LSB - REG_W;
    localparam int unsigned RD_LSB  = RT_LSB - REG_W;
    localparam int unsigned SH_LSB  = RD_LSB - REG_W;

    always_comb begin
        fields_o.opc   = instr_i[IW-1 -: OPC_W];
        fields_o.rs    = instr_i[RS_LSB +: REG_W];
        fields_o.rt    = instr_i[RT_LSB +: REG_W];
        fields_o.rd    = instr_i[RD_LSB +: REG_W];
        fields_o.shamt = instr_i[SH_LSB +: REG_W];
        fields_o.funct = instr_i[FN_W-1:0];
        fields_o.imm   = instr_i[IMM_W-1:0];
        fields_o.tgt   = instr_i[TGT_W-1:0];
    end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [FN_W-1:0]  funct_i,
    output ctrl_t            ctrl_o
);
    ctrl_t rfmt;

    // register-format decode by function code
    always_comb begin
        rfmt = ctrl_quiet();
        unique case (funct_i)
            FN_ADD:  begin rfmt = ctrl_alu(ALU_ADD, DST_RD, EXT_SIGN); rfmt.ovf_chk = 1'b1; end
            FN_ADDU: rfmt = ctrl_alu(ALU_ADD,  DST_RD, EXT_SIGN);
            FN_SUB:  begin rfmt = ctrl_alu(ALU_SUB, DST_RD, EXT_SIGN); rfmt.ovf_chk = 1'b1; end
            FN_SUBU: rfmt = ctrl_alu(ALU_SUB,  DST_RD, EXT_SIGN);
            FN_AND:  rfmt = ctrl_alu(ALU_AND,  DST_RD, EXT_SIGN);
            FN_OR:   rfmt = ctrl_alu(ALU_OR,   DST_RD, EXT_SIGN);
            FN_XOR:  rfmt = ctrl_alu(ALU_XOR,  DST_RD, EXT_SIGN);
            FN_NOR:  rfmt = ctrl_alu(ALU_NOR,  DST_RD, EXT_SIGN);
            FN_SLT:  rfmt = ctrl_alu(ALU_SLT,  DST_RD, EXT_SIGN);
            FN_SLTU: rfmt = ctrl_alu(ALU_SLTU, DST_RD, EXT_SIGN);
            FN_SLL:  rfmt = ctrl_alu(ALU_SLL,  DST_RD, EXT_SIGN);
            FN_SRL:  rfmt = ctrl_alu(ALU_SRL,  DST_RD, EXT_SIGN);
            FN_SRA:  rfmt = ctrl_alu(ALU_SRA,  DST_RD, EXT_SIGN);
            FN_JR:   rfmt.jmp_reg = 1'b1;
            default: rfmt.illegal = 1'b1;
        endcase
    end

    // opcode decode
    always_comb begin
        ctrl_o = ctrl_quiet();
        unique case (opc_i)
            OP_RFMT:  ctrl_o = rfmt;
            OP_J:     ctrl_o.jmp = 1'b1;
            OP_JAL:   begin
                ctrl_o.jmp  = 1'b1;
                ctrl_o.link = 1'b1;
                ctrl_o.dst  = DST_LINK;
            end
            OP_BEQ:   begin ctrl_o = ctrl_alu(ALU_SUB, DST_NONE, EXT_SIGN); ctrl_o.br_eq = 1'b1; end
            OP_BNE:   begin ctrl_o = ctrl_alu(ALU_SUB, DST_NONE, EXT_SIGN); ctrl_o.br_ne = 1'b1; end
            OP_ADDI:  begin ctrl_o = ctrl_alu(ALU_ADD, DST_RT, EXT_SIGN); ctrl_o.ovf_chk = 1'b1; end
            OP_ADDIU: ctrl_o = ctrl_alu(ALU_ADD,  DST_RT, EXT_SIGN);
            OP_SLTI:  ctrl_o = ctrl_alu(ALU_SLT,  DST_RT, EXT_SIGN);
            OP_SLTIU: ctrl_o = ctrl_alu(ALU_SLTU, DST_RT, EXT_SIGN);
            OP_ANDI:  ctrl_o = ctrl_alu(ALU_AND,  DST_RT, EXT_ZERO);
            OP_ORI:   ctrl_o = ctrl_alu(ALU_OR,   DST_RT, EXT_ZERO);
            OP_XORI:  ctrl_o = ctrl_alu(ALU_XOR,  DST_RT, EXT_ZERO);
            OP_LUI:   ctrl_o = ctrl_alu(ALU_LUI,  DST_RT, EXT_UPPER);
            OP_LW:    begin ctrl_o = ctrl_alu(ALU_ADD, DST_RT, EXT_SIGN); ctrl_o.mem_rd = 1'b1; end
            OP_SW:    begin ctrl_o = ctrl_alu(ALU_ADD, DST_NONE, EXT_SIGN); ctrl_o.mem_wr = 1'b1; end
            default:  ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/idec_imm.sv
module idec_imm
    import idec_pkg::*;
(
    input  logic [IMM_W-1:0] imm_i,
    input  ext_e             mode_i,
    output logic [IW-1:0]    imm_o
);
    always_comb begin
        unique case (mode_i)
            EXT_ZERO:  imm_o = {{EXT_W{1'b0}}, imm_i};
            EXT_UPPER: imm_o = {imm_i, {EXT_W{1'b0}}};
            default:   imm_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        endcase
    end
endmodule

// File: rtl/idec_top.sv
module idec_top
    import idec_pkg::*;
#(
    parameter bit REGISTERED = 1'b0
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IW-1:0]        instr_i,
    output logic [REG_W-1:0]     rs_o,
    output logic [REG_W-1:0]     rt_o,
    output logic [REG_W-1:0]     dst_o,
    output logic [REG_W-1:0]     shamt_o,
    output logic [IW-1:0]        imm_o,
    output logic [TGT_W-1:0]     jtgt_o,
    output logic [3:0]           alu_op_o,
    output logic                 reg_we_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic                 br_eq_o,
    output logic                 br_ne_o,
    output logic                 jump_o,
    output logic                 jump_reg_o,
    output logic                 link_o,
    output logic                 ovf_chk_o,
    output logic                 illegal_o
);
    fields_t          fld;
    ctrl_t            ctl;
    logic [IW-1:0]    imm_ext;
    logic [REG_W-1:0] dst_idx;
    dec_out_t         dec_c;
    dec_out_t         dec_q;

    idec_fields u_fields (
        .instr_i  (instr_i),
        .fields_o (fld)
    );

    idec_ctrl u_ctrl (
        .opc_i   (fld.opc),
        .funct_i (fld.funct),
        .ctrl_o  (ctl)
    );

    idec_imm u_imm (
        .imm_i  (fld.imm),
        .mode_i (ctl.ext),
        .imm_o  (imm_ext)
    );

    // destination by format
    always_comb begin
        unique case (ctl.dst)
            DST_RD:   dst_idx = fld.rd;
            DST_RT:   dst_idx = fld.rt;
            DST_LINK: dst_idx = LINK_REG;
            default:  dst_idx = '0;
        endcase
    end

    always_comb begin
        dec_c         = '0;
        dec_c.rs      = fld.rs;
        dec_c.rt      = fld.rt;
        dec_c.dst     = dst_idx;
        dec_c.shamt   = fld.shamt;
        dec_c.imm     = imm_ext;
        dec_c.tgt     = fld.tgt;
        dec_c.alu     = ctl.alu;
        dec_c.we      = (ctl.dst != DST_NONE) && (dst_idx != '0) && !ctl.illegal;
        dec_c.mem_rd  = ctl.mem_rd;
        dec_c.mem_wr  = ctl.mem_wr;
        dec_c.br_eq   = ctl.br_eq;
        dec_c.br_ne   = ctl.br_ne;
        dec_c.jmp     = ctl.jmp;
        dec_c.jmp_reg = ctl.jmp_reg;
        dec_c.link    = ctl.link;
        dec_c.ovf_chk = ctl.ovf_chk;
        dec_c.illegal = ctl.illegal;
    end

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) dec_q <= '0;
                else     dec_q <= dec_c;
            end
        end else begin : g_comb
            assign dec_q = dec_c;
        end
    endgenerate

    assign rs_o       = dec_q.rs;
    assign rt_o       = dec_q.rt;
    assign dst_o      = dec_q.dst;
    assign shamt_o    = dec_q.shamt;
    assign imm_o      = dec_q.imm;
    assign jtgt_o     = dec_q.tgt;
    assign alu_op_o   = dec_q.alu;
    assign reg_we_o   = dec_q.we;
    assign mem_rd_o   = dec_q.mem_rd;
    assign mem_wr_o   = dec_q.mem_wr;
    assign br_eq_o    = dec_q.br_eq;
    assign br_ne_o    = dec_q.br_ne;
    assign jump_o     = dec_q.jmp;
    assign jump_reg_o = dec_q.jmp_reg;
    assign link_o     = dec_q.link;
    assign ovf_chk_o  = dec_q.ovf_chk;
    assign illegal_o  = dec_q.illegal;

    // checks on the outputs
    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !(reg_we_o || mem_rd_o || mem_wr_o || br_eq_o || br_ne_o ||
                        jump_o || jump_reg_o || link_o || ovf_chk_o));

    assert_zero_dest_R4: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> (dst_o != '0));

    assert_link_dest_R9: assert property (@(posedge clk) disable iff (rst)
        link_o |-> (jump_o && reg_we_o && dst_o == LINK_REG));

    assert_mem_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    assert_lui_low_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_op_o == ALU_LUI) |-> (imm_o[EXT_W-1:0] == '0));

    assert_branch_nowr_R8: assert property (@(posedge clk) disable iff (rst)
        (br_eq_o || br_ne_o) |-> (!reg_we_o && $onehot0({br_eq_o, br_ne_o, jump_o, jump_reg_o})));
endmodule

// File: tb/test_idec_top.sv
module test_idec_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] instr = 32'h0;

    always #2 clk = ~clk;   // 250 MHz

    // combinational copy
    logic [4:0]  c_rs, c_rt, c_dst, c_sh;
    logic [31:0] c_imm;
    logic [25:0] c_tgt;
    logic [3:0]  c_alu;
    logic c_we, c_mr, c_mw, c_beq, c_bne, c_j, c_jr, c_lk, c_ov, c_il;

    // registered copy
    logic [4:0]  q_rs, q_rt, q_dst, q_sh;
    logic [31:0] q_imm;
    logic [25:0] q_tgt;
    logic [3:0]  q_alu;
    logic q_we, q_mr, q_mw, q_beq, q_bne, q_j, q_jr, q_lk, q_ov, q_il;

    idec_top #(.REGISTERED(1'b0)) i_idec_top (
        .clk(clk), .rst(rst), .instr_i(instr),
        .rs_o(c_rs), .rt_o(c_rt), .dst_o(c_dst), .shamt_o(c_sh), .imm_o(c_imm),
        .jtgt_o(c_tgt), .alu_op_o(c_alu), .reg_we_o(c_we), .mem_rd_o(c_mr),
        .mem_wr_o(c_mw), .br_eq_o(c_beq), .br_ne_o(c_bne), .jump_o(c_j),
        .jump_reg_o(c_jr), .link_o(c_lk), .ovf_chk_o(c_ov), .illegal_o(c_il)
    );

    idec_top #(.REGISTERED(1'b1)) i_idec_top_reg (
        .clk(clk), .rst(rst), .instr_i(instr),
        .rs_o(q_rs), .rt_o(q_rt), .dst_o(q_dst), .shamt_o(q_sh), .imm_o(q_imm),
        .jtgt_o(q_tgt), .alu_op_o(q_alu), .reg_we_o(q_we), .mem_rd_o(q_mr),
        .mem_wr_o(q_mw), .br_eq_o(q_beq), .br_ne_o(q_bne), .jump_o(q_j),
        .jump_reg_o(q_jr), .link_o(q_lk), .ovf_chk_o(q_ov), .illegal_o(q_il)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 92-bit packed view: {rs,rt,sh,tgt,imm,dst,alu,we,mr,mw,beq,bne,j,jr,lk,ov,il}
    function automatic logic [91:0] pack_c();
        return {c_rs, c_rt, c_sh, c_tgt, c_imm, c_dst, c_alu,
                c_we, c_mr, c_mw, c_beq, c_bne, c_j, c_jr, c_lk, c_ov, c_il};
    endfunction
    function automatic logic [91:0] pack_q();
        return {q_rs, q_rt, q_sh, q_tgt, q_imm, q_dst, q_alu,
                q_we, q_mr, q_mw, q_beq, q_bne, q_j, q_jr, q_lk, q_ov, q_il};
    endfunction

    // expected decode computed from the requirements
    function automatic logic [91:0] model(input logic [31:0] w);
        logic [5:0] op, fn;
        logic [4:0] rs, rt, rd, sh, dst;
        logic [15:0] i16;
        logic [31:0] imm;
        logic [3:0] alu;
        logic wr, mr, mw, beq, bne, j, jr, lk, ov, il;
        int kind;   // 0 none, 1 rd, 2 rt, 3 link
        op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
        sh = w[10:6];  fn = w[5:0];   i16 = w[15:0];
        imm = {{16{i16[15]}}, i16};
        alu = 4'd0; kind = 0;
        mr = 0; mw = 0; beq = 0; bne = 0; j = 0; jr = 0; lk = 0; ov = 0; il = 0;
        case (op)
            6'd0: begin
                kind = 1;
                case (fn)
                    6'h20: begin alu = 0; ov = 1; end
                    6'h21: alu = 0;
                    6'h22: begin alu = 1; ov = 1; end
                    6'h23: alu = 1;
                    6'h24: alu = 2;
                    6'h25: alu = 3;
                    6'h26: alu = 4;
                    6'h27: alu = 5;
                    6'h2A: alu = 6;
                    6'h2B: alu = 7;
                    6'h00: alu = 8;
                    6'h02: alu = 9;
                    6'h03: alu = 10;
                    6'h08: begin kind = 0; jr = 1; end
                    default: begin kind = 0; il = 1; end
                endcase
            end
            6'd2:  j = 1;
            6'd3:  begin j = 1; lk = 1; kind = 3; end
            6'd4:  begin beq = 1; alu = 1; end
            6'd5:  begin bne = 1; alu = 1; end
            6'd8:  begin kind = 2; ov = 1; end
            6'd9:  kind = 2;
            6'd10: begin kind = 2; alu = 6; end
            6'd11: begin kind = 2; alu = 7; end
            6'd12: begin kind = 2; alu = 2; imm = {16'h0, i16}; end
            6'd13: begin kind = 2; alu = 3; imm = {16'h0, i16}; end
            6'd14: begin kind = 2; alu = 4; imm = {16'h0, i16}; end
            6'd15: begin kind = 2; alu = 11; imm = {i16, 16'h0}; end
            6'd35: begin kind = 2; mr = 1; end
            6'd43: mw = 1;
            default: il = 1;
        endcase
        dst = (kind == 1) ? rd : (kind == 2) ? rt : (kind == 3) ? 5'd31 : 5'd0;
        wr  = (kind != 0) && (dst != 5'd0);
        return {rs, rt, sh, w[25:0], imm, dst, alu, wr, mr, mw, beq, bne, j, jr, lk, ov, il};
    endfunction

    function automatic string req_of(input logic [31:0] w);
        logic [5:0] op;
        op = w[31:26];
        if (model(w)[0]) return "R11";
        case (op)
            6'd0:  return (w[5:0] == 6'h08) ? "R9" : "R2/R3/R4/R10";
            6'd2, 6'd3: return "R9";
            6'd4, 6'd5: return "R8";
            6'd15: return "R6";
            6'd35, 6'd43: return "R7";
            default: return "R5/R3/R4/R10";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [91:0] act, input logic [91:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one word; check combinational copy, then registered copy one edge later
    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        #1;
        cmp({req_of(w), " R1 comb"}, pack_c(), model(w));
        @(posedge clk);
        #1;
        cmp({req_of(w), " R12 reg"}, pack_q(), model(w));
    endtask

    function automatic logic [31:0] word(input int op, input int fn, input int p);
        logic [4:0] rs, rt, rd, sh;
        case (p)
            0: begin rs = 5'd0;  rt = 5'd0;  rd = 5'd0;  sh = 5'd0;  end
            1: begin rs = 5'd9;  rt = 5'd5;  rd = 5'd17; sh = 5'd21; end
            2: begin rs = 5'd31; rt = 5'd31; rd = 5'd3;  sh = 5'd7;  end
            default: begin rs = 5'(op + 1); rt = 5'(op * 3 + 2); rd = 5'(fn * 5 + 30); sh = 5'(op ^ fn); end
        endcase
        return {6'(op), rs, rt, rd, sh, 6'(fn)};
    endfunction

    initial begin
        // reset state of the registered copy (R12)
        repeat (3) @(posedge clk);
        #1;
        cmp("R12 reset", pack_q(), 92'h0);
        @(negedge clk);
        instr = 32'hFFFF_FFFF;
        @(posedge clk);
        #1;
        cmp("R12 reset holds", pack_q(), 92'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1 field extraction on a dense pattern
        apply(32'hA5A5_5A5A);
        apply(32'h0000_0000);   // sll r0 -> no write (R4)

        // sweep every opcode with four field patterns
        for (int op = 1; op < 64; op++)
            for (int p = 0; p < 4; p++)
                apply(word(op, (op * 11) & 63, p));

        // sweep every function code under opcode 0
        for (int fn = 0; fn < 64; fn++)
            for (int p = 0; p < 4; p++)
                apply(word(0, fn, p));

        // boundary immediates for extension (R5, R6)
        apply({6'd12, 5'd1, 5'd2, 16'h8000});
        apply({6'd8,  5'd1, 5'd2, 16'h8000});
        apply({6'd15, 5'd0, 5'd7, 16'hFFFF});
        apply({6'd3,  26'h3FF_FFFF});      // jal link to 31 (R9)

        // reset again mid-stream clears the register (R12)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        cmp("R12 mid reset", pack_q(), 92'h0);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule